// File: doc/BRIEF.md
# Page Table Entry Check Unit

This block is one stage of a page-table walker. The walker hands it each page table entry it fetches from memory, together with the translation context. In the next cycle the block returns a verdict. The verdict says whether the entry is unusable, whether it points to the next table level, or whether it is a leaf, and whether that leaf can be used as it stands or needs an accessed/dirty update. The block also extracts the physical page number.

Two per-entry checks depend on configuration enables: the memory-type field check and the permission to update the accessed/dirty bits in hardware. Each check uses an effective enable. The effective enable is the machine-level bit alone, except on the first stage of a two-stage translation while virtualization is on. In that case the hypervisor-level bit must also be set. The width of the page-number field depends on the translation mode. In 64-bit mode it also depends on whether the upper attribute bits are reserved, either by the effective memory-type enable or by the `POW2_PAGES` parameter.

The block holds no state apart from its output register. Each input beat produces exactly one result beat one cycle later, and back-to-back beats are accepted every cycle.

Top module: `pte_chk_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `out_valid`=0, `result`=0, `ppn`=0 and `pte_out`=0.
- R2: A beat presented with `in_valid`=1 at a rising edge appears on the outputs after that same edge with `out_valid`=1. Beats may arrive back to back. `out_valid` is 0 after any edge where `in_valid` was 0.
- R3: The effective memory-type enable is `m_mtype_en`. When `first_stage`, `two_stage` and `virt_on` are all 1, it is `m_mtype_en & h_mtype_en`. The effective update enable is formed the same way from `m_ad_en` and `h_ad_en`.
- R4: An entry whose bit 0 (valid) is clear gives result code 4 (invalid fault), whatever its other bits are.
- R5: In 64-bit mode (`mode64`=1), a valid entry whose memory-type field (bits 62:61) is nonzero gives code 5 (memory-type fault) when the effective memory-type enable is 0. This check takes priority over the pointer check and the update check.
- R6: A valid entry that passes R5 and has R, W and X (bits 1, 2, 3) all clear gives code 2 (pointer). No accessed/dirty test applies to a pointer.
- R7: A leaf needs an update when A (bit 6) is clear, or when `is_store`=1 and D (bit 7) is clear. If an update is needed and the effective update enable is 0, the result is code 6 (update fault). If it is needed and the enable is 1, the result is code 1 (leaf with update), and `pte_out` equals the entry with A set and, on a store, D set. If no update is needed, the result is code 0 (leaf) and `pte_out` equals the entry.
- R8: In 32-bit mode (`mode64`=0), only the low 32 entry bits are used. `ppn` is entry bits 31:10. Bits 63:32 are ignored: they cause no memory-type fault and read as zero in `ppn` and `pte_out`.
- R9: In 64-bit mode, `ppn` is entry bits 53:10 with its upper bits zero when the effective memory-type enable is 1 or `POW2_PAGES` is 1. Otherwise `ppn` is entry bits 63:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An entry is presented this cycle |
| pte_in | input | PTE_W | Fetched page table entry |
| mode64 | input | 1 | 1: 64-bit translation mode, 0: 32-bit |
| first_stage | input | 1 | Walk belongs to the first (guest) stage |
| two_stage | input | 1 | Translation has two stages |
| virt_on | input | 1 | Virtualization is active |
| m_mtype_en | input | 1 | Machine-level memory-type enable |
| h_mtype_en | input | 1 | Hypervisor-level memory-type enable |
| m_ad_en | input | 1 | Machine-level hardware A/D update enable |
| h_ad_en | input | 1 | Hypervisor-level hardware A/D update enable |
| is_store | input | 1 | The access is a store |
| out_valid | output | 1 | Result is valid |
| result | output | 3 | Verdict code (0 leaf, 1 leaf with update, 2 pointer, 4/5/6 faults) |
| ppn | output | PTE_W-10 | Extracted physical page number |
| pte_out | output | PTE_W | Entry, with A/D set when the update is permitted |

## Verification
The bench provokes, within one entry, conditions for the memory-type fault, the update fault and the pointer decision at the same time. Entries carry a nonzero memory-type field, a clear A bit and a store access, with the effective enables switched off or on. The verdict must follow the fixed priority: valid first, then memory type, then pointer or leaf, then update. Expected codes come from that order and are compared in arrival order through a scoreboard queue, with beats streamed back to back. The same entries also drive the memory-type enable into page-number extraction at the same time as the fault check. Two instances, one per `POW2_PAGES` setting, show the masked and unmasked page numbers side by side.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  typedef enum logic [2:0] {
    RES_LEAF     = 3'd0,
    RES_LEAF_UPD = 3'd1,
    RES_POINTER  = 3'd2,
    RES_F_INVAL  = 3'd4,
    RES_F_MTYPE  = 3'd5,
    RES_F_AD     = 3'd6
  } pte_res_e;

  localparam int unsigned BIT_V = 0;
  localparam int unsigned BIT_R = 1;
  localparam int unsigned BIT_W = 2;
  localparam int unsigned BIT_X = 3;
  localparam int unsigned BIT_A = 6;
  localparam int unsigned BIT_D = 7;
endpackage

// File: rtl/pte_chk_enables.sv
module pte_chk_enables (
  input  logic first_stage,
  input  logic two_stage,
  input  logic virt_on,
  input  logic m_mtype_en,
  input  logic h_mtype_en,
  input  logic m_ad_en,
  input  logic h_ad_en,
  output logic eff_mtype,
  output logic eff_ad
);
  logic guest_walk;

  always_comb begin
    guest_walk = first_stage & two_stage & virt_on;
    eff_mtype  = m_mtype_en & (~guest_walk | h_mtype_en);
    eff_ad     = m_ad_en & (~guest_walk | h_ad_en);
  end
endmodule

// File: rtl/pte_chk_ppn.sv
module pte_chk_ppn #(
  parameter int unsigned PTE_W      = 64,
  parameter int unsigned PPN_LSB    = 10,
  parameter int unsigned PPN_MSB    = 53,
  parameter int unsigned NARROW_W   = 32,
  parameter bit          POW2_PAGES = 1'b0
) (
  input  logic [PTE_W-1:0]         pte,
  input  logic                     mode64,
  input  logic                     eff_mtype,
  output logic [PTE_W-PPN_LSB-1:0] ppn
);
  localparam int unsigned PPN_W    = PTE_W - PPN_LSB;
  localparam int unsigned MASK_W   = PPN_MSB - PPN_LSB + 1;
  localparam int unsigned NARR_PPN = NARROW_W - PPN_LSB;

  logic [PPN_W-1:0] ppn_narrow;
  logic [PPN_W-1:0] ppn_masked;
  logic [PPN_W-1:0] ppn_full;
  logic             use_mask;

  always_comb begin
    ppn_narrow = {{(PPN_W-NARR_PPN){1'b0}}, pte[NARROW_W-1:PPN_LSB]};
    ppn_masked = {{(PPN_W-MASK_W){1'b0}}, pte[PPN_MSB:PPN_LSB]};
    ppn_full   = pte[PTE_W-1:PPN_LSB];
  end

  generate
    if (POW2_PAGES) begin : g_pow2
      always_comb use_mask = 1'b1;
    end else begin : g_plain
      always_comb use_mask = eff_mtype;
    end
  endgenerate

  always_comb begin
    if (!mode64)       ppn = ppn_narrow;
    else if (use_mask) ppn = ppn_masked;
    else               ppn = ppn_full;
  end
endmodule

// File: rtl/pte_chk_classify.sv
module pte_chk_classify
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W    = 64,
  parameter int unsigned MT_HI    = 62,
  parameter int unsigned MT_LO    = 61,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [PTE_W-1:0] pte_raw,
  input  logic             mode64,
  input  logic             eff_mtype,
  input  logic             eff_ad,
  input  logic             is_store,
  output logic [PTE_W-1:0] pte_used,
  output pte_res_e         res,
  output logic [PTE_W-1:0] pte_new
);
  logic mt_bad, is_ptr, need_a, need_d;

  always_comb begin
    if (mode64) pte_used = pte_raw;
    else        pte_used = {{(PTE_W-NARROW_W){1'b0}}, pte_raw[NARROW_W-1:0]};

    mt_bad = mode64 && (pte_used[MT_HI:MT_LO] != '0) && !eff_mtype;
    is_ptr = !pte_used[BIT_R] && !pte_used[BIT_W] && !pte_used[BIT_X];
    need_a = !pte_used[BIT_A];
    need_d = is_store && !pte_used[BIT_D];

    pte_new = pte_used;
    if (!pte_used[BIT_V])          res = RES_F_INVAL;
    else if (mt_bad)               res = RES_F_MTYPE;
    else if (is_ptr)               res = RES_POINTER;
    else if ((need_a || need_d) && !eff_ad) res = RES_F_AD;
    else if (need_a || need_d) begin
      res = RES_LEAF_UPD;
      pte_new[BIT_A] = 1'b1;
      if (is_store) pte_new[BIT_D] = 1'b1;
    end else                       res = RES_LEAF;
  end
endmodule

// File: rtl/pte_chk_unit.sv
module pte_chk_unit
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W      = 64,
  parameter int unsigned PPN_LSB    = 10,
  parameter int unsigned PPN_MSB    = 53,
  parameter int unsigned MT_HI      = 62,
  parameter int unsigned MT_LO      = 61,
  parameter int unsigned NARROW_W   = 32,
  parameter bit          POW2_PAGES = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PTE_W-1:0]         pte_in,
  input  logic                     mode64,
  input  logic                     first_stage,
  input  logic                     two_stage,
  input  logic                     virt_on,
  input  logic                     m_mtype_en,
  input  logic                     h_mtype_en,
  input  logic                     m_ad_en,
  input  logic                     h_ad_en,
  input  logic                     is_store,
  output logic                     out_valid,
  output logic [2:0]               result,
  output logic [PTE_W-PPN_LSB-1:0] ppn,
  output logic [PTE_W-1:0]         pte_out
);
  localparam int unsigned PPN_W = PTE_W - PPN_LSB;

  logic             eff_mtype, eff_ad;
  logic [PTE_W-1:0] pte_used, pte_new;
  pte_res_e         res_c;
  logic [PPN_W-1:0] ppn_c;

  pte_chk_enables u_en (
    .first_stage(first_stage), .two_stage(two_stage), .virt_on(virt_on),
    .m_mtype_en(m_mtype_en), .h_mtype_en(h_mtype_en),
    .m_ad_en(m_ad_en), .h_ad_en(h_ad_en),
    .eff_mtype(eff_mtype), .eff_ad(eff_ad)
  );

  pte_chk_classify #(
    .PTE_W(PTE_W), .MT_HI(MT_HI), .MT_LO(MT_LO), .NARROW_W(NARROW_W)
  ) u_cls (
    .pte_raw(pte_in), .mode64(mode64), .eff_mtype(eff_mtype), .eff_ad(eff_ad),
    .is_store(is_store), .pte_used(pte_used), .res(res_c), .pte_new(pte_new)
  );

  pte_chk_ppn #(
    .PTE_W(PTE_W), .PPN_LSB(PPN_LSB), .PPN_MSB(PPN_MSB),
    .NARROW_W(NARROW_W), .POW2_PAGES(POW2_PAGES)
  ) u_ppn (
    .pte(pte_used), .mode64(mode64), .eff_mtype(eff_mtype), .ppn(ppn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= 3'd0;
      ppn       <= '0;
      pte_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_c;
        ppn     <= ppn_c;
        pte_out <= pte_new;
      end
    end
  end
endmodule

// File: rtl/pte_chk_unit_sva.sv
module pte_chk_unit_sva #(
  parameter int unsigned PTE_W   = 64,
  parameter int unsigned PPN_LSB = 10,
  parameter int unsigned MT_HI   = 62,
  parameter int unsigned MT_LO   = 61
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [PTE_W-1:0]         pte_in,
  input logic                     mode64,
  input logic                     is_store,
  input logic                     out_valid,
  input logic [2:0]               result,
  input logic [PTE_W-PPN_LSB-1:0] ppn,
  input logic [PTE_W-1:0]         pte_out
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == 3'd0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r4_invalid_fault: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pte_in[0]) |=> result == 3'd4);

  a_r6_pointer: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pte_in[0] && pte_in[3:1] == 3'b000 &&
     (!mode64 || pte_in[MT_HI:MT_LO] == 2'b00)) |=> result == 3'd2);

  a_r7_update_sets_a: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result == 3'd1) |-> pte_out[6]);

  a_r7_store_sets_d: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_store) |=> (result != 3'd1 || pte_out[7]));

  a_r8_narrow_ppn: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode64) |=> (ppn[PTE_W-PPN_LSB-1:32-PPN_LSB] == '0 &&
                               pte_out[PTE_W-1:32] == '0));
endmodule

bind pte_chk_unit pte_chk_unit_sva #(
  .PTE_W(PTE_W), .PPN_LSB(PPN_LSB), .MT_HI(MT_HI), .MT_LO(MT_LO)
) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pte_in(pte_in),
  .mode64(mode64), .is_store(is_store), .out_valid(out_valid),
  .result(result), .ppn(ppn), .pte_out(pte_out)
);

// File: tb/pte_chk_unit_tb.sv
module pte_chk_unit_tb;
  typedef struct {
    logic [2:0]  res;
    logic [53:0] ppn;
    logic [53:0] ppn_p2;
    logic [63:0] pte;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] pte_in = '0;
  logic mode64 = 1'b1, first_stage = 1'b0, two_stage = 1'b0, virt_on = 1'b0;
  logic m_mtype_en = 1'b0, h_mtype_en = 1'b0, m_ad_en = 1'b0, h_ad_en = 1'b0;
  logic is_store = 1'b0;
  logic        out_valid, out_valid_p2;
  logic [2:0]  result, result_p2;
  logic [53:0] ppn, ppn_p2;
  logic [63:0] pte_out, pte_out_p2;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pte_chk_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pte_in(pte_in), .mode64(mode64),
    .first_stage(first_stage), .two_stage(two_stage), .virt_on(virt_on),
    .m_mtype_en(m_mtype_en), .h_mtype_en(h_mtype_en), .m_ad_en(m_ad_en),
    .h_ad_en(h_ad_en), .is_store(is_store), .out_valid(out_valid),
    .result(result), .ppn(ppn), .pte_out(pte_out)
  );

  pte_chk_unit #(.POW2_PAGES(1'b1)) u_dut_p2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pte_in(pte_in), .mode64(mode64),
    .first_stage(first_stage), .two_stage(two_stage), .virt_on(virt_on),
    .m_mtype_en(m_mtype_en), .h_mtype_en(h_mtype_en), .m_ad_en(m_ad_en),
    .h_ad_en(h_ad_en), .is_store(is_store), .out_valid(out_valid_p2),
    .result(result_p2), .ppn(ppn_p2), .pte_out(pte_out_p2)
  );

  function automatic exp_t model(logic [63:0] p_raw, logic m64, logic fs, logic ts,
                                 logic vo, logic mm, logic hm, logic ma, logic ha,
                                 logic st, string tag);
    exp_t e;
    logic [63:0] p;
    logic guest, em, ea, need;
    p     = m64 ? p_raw : {32'h0, p_raw[31:0]};
    guest = fs && ts && vo;
    em    = mm && (!guest || hm);
    ea    = ma && (!guest || ha);
    need  = !p[6] || (st && !p[7]);
    e.tag = tag;
    e.pte = p;
    if (!p[0])                                  e.res = 3'd4;
    else if (m64 && p[62:61] != 2'b00 && !em)  e.res = 3'd5;
    else if (p[3:1] == 3'b000)                 e.res = 3'd2;
    else if (need && !ea)                      e.res = 3'd6;
    else if (need) begin
      e.res = 3'd1;
      e.pte[6] = 1'b1;
      if (st) e.pte[7] = 1'b1;
    end else                                   e.res = 3'd0;
    if (!m64) begin
      e.ppn    = {32'h0, p[31:10]};
      e.ppn_p2 = e.ppn;
    end else begin
      e.ppn_p2 = {10'h0, p[53:10]};
      e.ppn    = em ? e.ppn_p2 : p[63:10];
    end
    return e;
  endfunction

  task automatic drive(logic [63:0] p, logic m64, logic fs, logic ts, logic vo,
                       logic mm, logic hm, logic ma, logic ha, logic st, string tag);
    @(negedge clk);
    pte_in = p; mode64 = m64; first_stage = fs; two_stage = ts; virt_on = vo;
    m_mtype_en = mm; h_mtype_en = hm; m_ad_en = ma; h_ad_en = ha; is_store = st;
    in_valid = 1'b1;
    sb.push_back(model(p, m64, fs, ts, vo, mm, hm, ma, ha, st, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R2: out_valid=1 with no pending beat, expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (result !== e.res || ppn !== e.ppn || pte_out !== e.pte ||
            ppn_p2 !== e.ppn_p2 || result_p2 !== e.res) begin
          n_errors++;
          $display("FAIL %s: res=%0d ppn=%h pte=%h ppn_p2=%h, expected res=%0d ppn=%h pte=%h ppn_p2=%h",
                   e.tag, result, ppn, pte_out, ppn_p2, e.res, e.ppn, e.pte, e.ppn_p2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] leaf;
    leaf = 64'h0000_1234_5678_9C0F; // V R W X set, A/D clear
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== 3'd0 || ppn !== '0 || pte_out !== '0) begin
      n_errors++;
      $display("FAIL R1: valid=%b res=%0d ppn=%h pte=%h, expected all 0",
               out_valid, result, ppn, pte_out);
    end
    @(negedge clk); rst = 1'b0;

    // R4: invalid entry wins over every other condition
    drive(64'h6000_0000_0000_000E, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R4");
    // R5: memory-type field set, enable off
    drive(64'h2000_0000_0000_00CF, 1, 0, 0, 0, 0, 0, 1, 1, 0, "R5");
    // R3: guest walk, machine on hypervisor off -> still memory-type fault
    drive(64'h4000_0000_0000_00CF, 1, 1, 1, 1, 1, 0, 1, 1, 0, "R3");
    // R3: hypervisor bit ignored outside a guest walk
    drive(64'h4000_0000_0000_00CF, 1, 1, 1, 0, 1, 0, 1, 1, 0, "R3");
    // R5 beats R7: memory-type and update faults at once
    drive(64'h6000_0000_0000_000F, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R5");
    // R6: pointer with A clear and updates off
    drive(64'h0000_0000_1234_5401, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    // R5 beats R6: pointer with memory type set and enable off
    drive(64'h2000_0000_0000_0401, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R7: A and D already set, store -> plain leaf
    drive(leaf | 64'hC0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R7: store, update allowed -> A and D set
    drive(leaf, 1, 0, 0, 0, 0, 0, 1, 0, 1, "R7");
    // R7: load, A clear, update allowed -> only A set
    drive(leaf, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    // R7: load with A set, D clear -> no update needed
    drive(leaf | 64'h40, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R7: store, D clear, updates off -> update fault
    drive(leaf | 64'h40, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R3: guest walk, machine update on, hypervisor off -> update fault
    drive(leaf, 1, 1, 1, 1, 0, 0, 1, 0, 0, "R3");
    // R3: guest walk, both update bits on -> update
    drive(leaf, 1, 1, 1, 1, 0, 0, 1, 1, 0, "R3");
    // R8: 32-bit mode, upper garbage ignored
    drive(64'hFFFF_FFFF_ABCD_E4CF, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: 64-bit, enable off, upper bits carried (plain) / masked (pow2)
    drive(64'hFFC0_0000_0000_04CF, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
    drive(64'h9FC0_0000_0000_04CF, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    idle(3);
    n_checks++;
    if (out_valid !== 1'b0 || sb.size() != 0) begin
      n_errors++;
      $display("FAIL R2: out_valid=%b pending=%0d, expected 0 and 0", out_valid, sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule